// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single countdown timer behind a small synchronous register bus. Software picks a mode (free-running, periodic or one-shot), a counter size (16 or 32 bits) and a prescale factor (1, 16 or 256). It then writes a reload value and enables the timer. The counter steps down once per prescaled tick of the `tick_en` strobe. Each time it passes from 1 to 0, an expiry flag is latched. The flag drives a level interrupt, which is gated by an enable bit.

The reload value can be written in two ways. A write to the immediate port loads the counter at once. A write to the background port only replaces the value that the next automatic reload will use. In free-running mode the load value is ignored, and the counter wraps to the largest value for the selected size. Software can read the raw flag or the enable-gated flag, and any write to the clear port drops the flag.

Top module: `down_timer`

## Requirements
- R1: After a synchronous reset, the control word reads 0x20 (interrupt enable set, timer stopped, free-running, 16-bit). The counter reads 0, the raw flag reads 0 and `irq` is low.
- R2: Word 2 is the control word. Bit 7 = run, bit 6 = periodic, bit 5 = interrupt enable, bits 3:2 = prescale select, bit 1 = 32-bit size, bit 0 = one-shot. Reading word 2 returns the last written byte with bits 31:8 zero.
- R3: While running, the counter moves once every 1, 16 or 256 `tick_en` pulses, for prescale select 00, 01 or 10. Select 11 acts as 00. The prescaler restarts on a control write, on a word-0 write and while stopped.
- R4: With both periodic and one-shot clear, the reload value is 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode, whatever the stored load value.
- R5: In periodic mode, the counter reloads the stored load value on the prescaled tick after it reaches 0.
- R6: In one-shot mode, the counter stays at 0 after its expiry.
- R7: A write to word 0 stores the load value and, in the same cycle, sets the counter to the reload value for the current mode. This happens whether or not the timer runs.
- R8: A write to word 6 stores the load value only. The counter is unchanged, and the new value is used at the next automatic reload.
- R9: Reads of word 0 and word 6 both return the stored load value. Writes to word 1 leave the counter unchanged.
- R10: A 1-to-0 counter step sets the raw flag, which reads as bit 0 of word 4. Any write to word 3 clears it.
- R11: If an expiry and a word-3 write fall in the same cycle, the raw flag stays set.
- R12: `irq` equals the raw flag ANDed with the interrupt-enable bit. Word 5 returns that same value.
- R13: A control write with run set loads the counter with the reload value for the new mode. A control write with run clear leaves it as it was. While stopped, ticks have no effect.
- R14: In 16-bit mode only bits 15:0 count, and word 1 reads zero in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base-rate tick strobe, one cycle per tick |
| reg_addr | input | 3 | Word address of the register access |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
A wrong counter value appears on word 1 in the same cycle, because the read path has no register. A wrong reload choice therefore shows within one prescaled tick after the counter reaches 0. A flag that is set or cleared at the wrong time shows on `irq` and on words 4 and 5 one cycle after the expiry or the clear write that should have changed it. Prescaler drift is slower to appear: it shows only as a counter that steps a few base ticks early or late, so the prescale checks count out whole divide periods of 16 and 256.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int CNT_W    = 32;
    localparam int NARROW_W = 16;
    localparam int ADDR_W   = 3;
    localparam int PRE_W    = 8;

    localparam logic [ADDR_W-1:0] OFS_LOAD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_BGLOAD = 3'd6;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] presc;
        logic       wide;
        logic       single;
    } dtmr_ctrl_t;

    localparam dtmr_ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                          spare: 1'b0, presc: 2'b00, wide: 1'b0,
                                          single: 1'b0};

    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'b01:   return PRE_W'(15);
            2'b10:   return PRE_W'(255);
            default: return '0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] width_mask(input dtmr_ctrl_t c);
        return c.wide ? {CNT_W{1'b1}} : CNT_W'({NARROW_W{1'b1}});
    endfunction

    function automatic logic [CNT_W-1:0] reload_pick(input dtmr_ctrl_t c,
                                                     input logic [CNT_W-1:0] load);
        if (!c.periodic && !c.single) return width_mask(c);
        return load & width_mask(c);
    endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale import dtmr_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic       tick_en,
    input  logic [1:0] sel,
    output logic       ptick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last  = presc_last(sel);
        ptick = run && tick_en && !restart && (pre_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/dtmr_count.sv
module dtmr_count import dtmr_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  dtmr_ctrl_t       ctrl,
    input  logic             ctrl_we,
    input  dtmr_ctrl_t       ctrl_new,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_new,
    input  logic [CNT_W-1:0] load_q,
    input  logic             ptick,
    output logic [CNT_W-1:0] cnt_vis,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask    = width_mask(ctrl);
        cnt_vis = cnt_q & mask;
        expire  = ptick && (cnt_vis == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_we) begin
            if (ctrl_new.run) cnt_q <= reload_pick(ctrl_new, load_q);
        end else if (load_we) begin
            cnt_q <= reload_pick(ctrl, load_new);
        end else if (ptick) begin
            if (cnt_vis == '0) begin
                if (!ctrl.single) cnt_q <= reload_pick(ctrl, load_q);
            end else begin
                cnt_q <= (cnt_vis - 1'b1) & mask;
            end
        end
    end
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs import dtmr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  cnt_vis,
    output dtmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              raw_q,
    output logic              ctrl_we,
    output logic              load_imm_we,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    logic bg_we;
    logic clr_we;

    always_comb begin
        ctrl_we     = reg_we && (reg_addr == OFS_CTRL);
        load_imm_we = reg_we && (reg_addr == OFS_LOAD);
        bg_we       = reg_we && (reg_addr == OFS_BGLOAD);
        clr_we      = reg_we && (reg_addr == OFS_ICLR);
        irq         = raw_q && ctrl_q.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= dtmr_ctrl_t'(reg_wdata[7:0]);
            if (load_imm_we || bg_we) load_q <= reg_wdata;
            if (expire)      raw_q <= 1'b1;
            else if (clr_we) raw_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_LOAD, OFS_BGLOAD: reg_rdata = load_q;
            OFS_VALUE:            reg_rdata = cnt_vis;
            OFS_CTRL:             reg_rdata = CNT_W'(ctrl_q);
            OFS_RAW:              reg_rdata = CNT_W'(raw_q);
            OFS_MASKED:           reg_rdata = CNT_W'(irq);
            default:              reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/down_timer.sv
module down_timer import dtmr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    dtmr_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_vis;
    logic             raw_q;
    logic             ctrl_we;
    logic             load_imm_we;
    logic             ptick;
    logic             expire;

    dtmr_regs u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .expire(expire), .cnt_vis(cnt_vis),
        .ctrl_q(ctrl_q), .load_q(load_q), .raw_q(raw_q), .ctrl_we(ctrl_we),
        .load_imm_we(load_imm_we), .reg_rdata(reg_rdata), .irq(irq)
    );

    dtmr_prescale u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.run),
        .restart(ctrl_we || load_imm_we), .tick_en(tick_en),
        .sel(ctrl_q.presc), .ptick(ptick)
    );

    dtmr_count u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .ctrl_we(ctrl_we),
        .ctrl_new(dtmr_ctrl_t'(reg_wdata[7:0])), .load_we(load_imm_we),
        .load_new(reg_wdata), .load_q(load_q), .ptick(ptick),
        .cnt_vis(cnt_vis), .expire(expire)
    );
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk import dtmr_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              irq,
    input dtmr_ctrl_t        ctrl_q,
    input logic              raw_q,
    input logic [CNT_W-1:0]  cnt_vis,
    input logic              ptick,
    input logic              expire
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_RESET) && !raw_q && (cnt_vis == '0));

    p_expire_sets_r10: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw_q);

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_ICLR && !expire) |=> !raw_q);

    p_clear_race_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_ICLR && expire) |=> raw_q);

    p_irq_cause_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(expire) || $past(reg_we && reg_addr == OFS_CTRL)));

    p_value_ro_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_VALUE && !ptick) |=> $stable(cnt_vis));

    p_bgload_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_BGLOAD && !ptick) |=> $stable(cnt_vis));

    p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.single && cnt_vis == '0 && !reg_we) |=> (cnt_vis == '0));

    p_stopped_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !reg_we) |=> $stable(cnt_vis));
endmodule

bind down_timer dtmr_chk i_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .irq(irq),
    .ctrl_q(ctrl_q), .raw_q(raw_q), .cnt_vis(cnt_vis), .ptick(ptick),
    .expire(expire)
);

// File: tb/test_down_timer.sv
module test_down_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    down_timer i_down_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference
    bit [7:0]  m_ctrl;
    bit [31:0] m_load;
    bit [31:0] m_cnt;
    bit        m_raw;
    int        m_pre;

    function automatic bit [31:0] m_mask(bit [7:0] c);
        return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic bit [31:0] m_reload(bit [7:0] c, bit [31:0] l);
        if (!c[0] && !c[6]) return m_mask(c);
        return l & m_mask(c);
    endfunction

    function automatic int m_div(bit [7:0] c);
        if (c[3:2] == 2'd1) return 16;
        if (c[3:2] == 2'd2) return 256;
        return 1;
    endfunction

    function automatic bit [31:0] m_read(bit [2:0] a);
        case (a)
            3'd0, 3'd6: return m_load;
            3'd1:       return m_cnt & m_mask(m_ctrl);
            3'd2:       return {24'd0, m_ctrl};
            3'd4:       return {31'd0, m_raw};
            3'd5:       return {31'd0, m_raw & m_ctrl[5]};
            default:    return 32'd0;
        endcase
    endfunction

    task automatic m_step();
        bit exp_now;
        bit [31:0] v;
        exp_now = 1'b0;
        if (rst) begin
            m_ctrl = 8'h20; m_load = 0; m_cnt = 0; m_raw = 0; m_pre = 0;
            return;
        end
        if (reg_we && reg_addr == 3'd2) begin
            m_ctrl = reg_wdata[7:0];
            m_pre = 0;
            if (m_ctrl[7]) m_cnt = m_reload(m_ctrl, m_load);
        end else if (reg_we && reg_addr == 3'd0) begin
            m_load = reg_wdata;
            m_cnt = m_reload(m_ctrl, reg_wdata);
            m_pre = 0;
        end else if (!m_ctrl[7]) begin
            m_pre = 0;
        end else if (tick_en) begin
            m_pre++;
            if (m_pre == m_div(m_ctrl)) begin
                m_pre = 0;
                v = m_cnt & m_mask(m_ctrl);
                if (v == 0) begin
                    if (!m_ctrl[0]) m_cnt = m_reload(m_ctrl, m_load);
                end else begin
                    if (v == 1) exp_now = 1'b1;
                    m_cnt = (v - 1) & m_mask(m_ctrl);
                end
            end
        end
        if (reg_we && reg_addr == 3'd6) m_load = reg_wdata;
        if (exp_now) m_raw = 1'b1;
        else if (reg_we && reg_addr == 3'd3) m_raw = 1'b0;
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(bit [2:0] a);
        case (a)
            3'd1:    return "R5";
            3'd2:    return "R2";
            3'd4:    return "R10";
            3'd5:    return "R12";
            default: return "R9";
        endcase
    endfunction

    // per-cycle comparison against the reference
    always begin
        @(posedge clk);
        m_step();
        #1;
        check(reg_rdata === m_read(reg_addr), rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
        check(irq === (m_raw & m_ctrl[5]), "R12", {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
    end

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input bit [2:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd2, 32'h20, "R1");
        rd(3'd1, 32'h0, "R1");
        rd(3'd4, 32'h0, "R1");
        check(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);
        // R8, R9 background load while stopped
        wr(3'd6, 32'd3);
        rd(3'd1, 32'd0, "R8");
        rd(3'd0, 32'd3, "R9");
        rd(3'd6, 32'd3, "R9");
        // R13, R2 enable periodic 32-bit, interrupt on
        wr(3'd2, 32'hE2);
        rd(3'd1, 32'd3, "R13");
        rd(3'd2, 32'hE2, "R2");
        wr(3'd1, 32'h1234);
        rd(3'd1, 32'd3, "R9");
        wr(3'd0, 32'd7);
        rd(3'd1, 32'd7, "R7");
        wr(3'd6, 32'd2);
        rd(3'd1, 32'd7, "R8");
        rd(3'd0, 32'd2, "R9");
        ticks(7);
        rd(3'd1, 32'd0, "R5");
        rd(3'd4, 32'd1, "R10");
        check(irq === 1'b1, "R12", {31'd0, irq}, 32'd1);
        rd(3'd5, 32'd1, "R12");
        ticks(1);
        rd(3'd1, 32'd2, "R8");
        wr(3'd2, 32'hC2);
        check(irq === 1'b0, "R12", {31'd0, irq}, 32'd0);
        rd(3'd5, 32'd0, "R12");
        rd(3'd4, 32'd1, "R12");
        wr(3'd3, 32'd0);
        rd(3'd4, 32'd0, "R10");
        // R11 clear coincides with expiry
        ticks(1);
        @(negedge clk);
        tick_en = 1'b1; reg_we = 1'b1; reg_addr = 3'd3;
        @(negedge clk);
        tick_en = 1'b0; reg_we = 1'b0;
        rd(3'd4, 32'd1, "R11");
        wr(3'd3, 32'd0);
        // R4 free-running wrap values
        wr(3'd2, 32'h80);
        rd(3'd1, 32'h0000FFFF, "R4");
        ticks(1);
        rd(3'd1, 32'h0000FFFE, "R4");
        wr(3'd2, 32'h82);
        rd(3'd1, 32'hFFFFFFFF, "R4");
        wr(3'd0, 32'd5);
        rd(3'd1, 32'hFFFFFFFF, "R7");
        rd(3'd0, 32'd5, "R9");
        ticks(1);
        wr(3'd2, 32'h02);
        rd(3'd1, 32'hFFFFFFFE, "R13");
        wr(3'd2, 32'h00);
        rd(3'd1, 32'h0000FFFE, "R14");
        // R6 one-shot
        wr(3'd0, 32'd2);
        wr(3'd2, 32'hA1);
        rd(3'd1, 32'd2, "R13");
        ticks(2);
        rd(3'd4, 32'd1, "R6");
        ticks(3);
        rd(3'd1, 32'd0, "R6");
        wr(3'd3, 32'd0);
        // R3 prescale
        wr(3'd0, 32'd3);
        wr(3'd2, 32'hC4);
        ticks(15);
        rd(3'd1, 32'd3, "R3");
        ticks(1);
        rd(3'd1, 32'd2, "R3");
        wr(3'd2, 32'hC8);
        ticks(255);
        rd(3'd1, 32'd3, "R3");
        ticks(1);
        rd(3'd1, 32'd2, "R3");
        wr(3'd2, 32'hCC);
        ticks(1);
        rd(3'd1, 32'd2, "R3");
        // R13 stopped timer ignores ticks
        wr(3'd2, 32'h40);
        ticks(5);
        rd(3'd1, 32'd2, "R13");
        // mixed traffic against the reference
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick_en = ($urandom % 4) != 0;
            reg_we = ($urandom % 6) == 0;
            reg_addr = 3'($urandom % 8);
            if (reg_addr == 3'd2)
                reg_wdata = {24'd0, 8'($urandom) | (($urandom % 4) != 0 ? 8'h80 : 8'h00)};
            else
                reg_wdata = $urandom % 24;
            rst = (i == 3000);
        end
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0; rst = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule